// File: doc/BRIEF.md
# USB Endpoint Handshake Status Controller

This block holds an 8-bit status word for each non-isochronous endpoint of a USB device and chooses the handshake (ACK, NAK or STALL) for every SETUP, IN or OUT transaction. The bus side presents one event per finished transaction. Each event carries the endpoint number, the token kind, a strobe that marks the last transaction of a transfer, and the data PID of the received packet. The block answers on the following clock edge with a handshake code and, for IN data, the PID to transmit. In the same edge it updates the status word of that endpoint. Any completed transfer whose interrupt is not suppressed raises a sticky global interrupt flag.

Firmware and hardware share the same status bits. Firmware changes a word through a port that carries set, clear and toggle masks, so an update never overwrites a bit that hardware is changing in the same cycle. Firmware reads any word through a combinational read port. Per-endpoint control inputs select control-endpoint behaviour, force STALL, and suppress the interrupt.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After reset every status word reads 0x00, `hs_code` is 0 (none) and `tc_irq` is 0.
- R2: A SETUP event (kind 2) is always answered ACK (code 1), even when the endpoint's stall input, buffer-hold bit or setup-pending bit is set. It sets setup-pending (bit 4) and buffer-hold (bit 1), and it sets the toggle (bit 0) to 1.
- R3: When the endpoint's stall input is 1, an IN (kind 1) or OUT (kind 0) event is answered STALL (code 3). This sets the stalled bit (bit 3) and changes nothing else. It takes priority over every NAK cause.
- R4: On an endpoint marked as control, an IN or OUT event while setup-pending is 1 is answered NAK (code 2) and sets the under/overflow bit (bit 6).
- R5: An IN or OUT event while buffer-hold is 1 is answered NAK and sets bit 6. The toggle and the other bits stay unchanged.
- R6: An IN event that is not stalled or NAKed is answered ACK. `tx_pid` carries the toggle value from before the event (0 = DATA0, 1 = DATA1). The toggle then inverts and buffer-hold is set. In all other cases `tx_pid` is 0.
- R7: An OUT event whose `rx_pid` equals the toggle and that is not stalled or NAKed is answered ACK. The toggle inverts and buffer-hold is set.
- R8: An OUT event whose `rx_pid` differs from the toggle is answered ACK, and the status word does not change.
- R9: The transaction-complete bit (bit 5) is set only by an accepted IN or OUT that has `tok_last` = 1. In that case `tc_irq` is also set, unless the endpoint's interrupt-disable input is 1.
- R10: `tc_irq` stays set until `irq_clr` is 1. A new set in the same cycle as `irq_clr` wins.
- R11: A firmware write produces ((word | set) & ~clr) ^ tgl. Bits 7 and 2 always read 0.
- R12: When hardware sets a bit or updates the toggle in the same cycle as a firmware write to that endpoint, the hardware value wins for the bits it touches.
- R13: `hs_code` is registered. It shows the response one cycle after the event and shows 0 after any cycle without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | A transaction event is present |
| tok_ep | input | EPW | Endpoint number of the event |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| tok_last | input | 1 | Event is the last transaction of its transfer |
| rx_pid | input | 1 | Received data PID, 0 DATA0, 1 DATA1 |
| ep_ctrl_type | input | NUM_EP | Endpoint is a control endpoint |
| ep_stall_en | input | NUM_EP | Endpoint answers IN/OUT with STALL |
| ep_tc_irq_dis | input | NUM_EP | Suppress interrupt on transfer completion |
| sw_we | input | 1 | Firmware status update strobe |
| sw_ep | input | EPW | Endpoint addressed by the update |
| sw_set | input | 8 | Bits to set |
| sw_clr | input | 8 | Bits to clear |
| sw_tgl | input | 8 | Bits to invert |
| rd_ep | input | EPW | Endpoint whose word is read |
| rd_status | output | 8 | Status word of `rd_ep` |
| irq_clr | input | 1 | Clear the global interrupt flag |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| tx_pid | output | 1 | PID of IN data being sent |
| tc_irq | output | 1 | Global transaction-complete flag |

## Verification
Directed sequences drive a control endpoint through SETUP, then a NAK caused by the pending setup, then an accepted IN. They also drive a bulk endpoint through a matching OUT and a mismatched OUT. These runs separate the NAK causes from one another and from STALL, and separate an accepted OUT from a discarded one. Other directed cases put a hardware set and a firmware clear on the same endpoint in one cycle, and an interrupt set together with `irq_clr`, to show which side wins. Random events, interleaved with random mask writes and changing control inputs, then compare every response, PID and touched status word against a bench model. This catches wrong priority orders and toggle errors that only appear after long histories.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    localparam int ST_W = 8;

    localparam int B_TGL  = 0;
    localparam int B_HOLD = 1;
    localparam int B_STL  = 3;
    localparam int B_SETP = 4;
    localparam int B_TC   = 5;
    localparam int B_UOF  = 6;

    localparam logic [ST_W-1:0] ST_USED = 8'h7B;

    typedef enum logic [1:0] {
        TK_OUT   = 2'b00,
        TK_IN    = 2'b01,
        TK_SETUP = 2'b10,
        TK_RSVD  = 2'b11
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef struct packed {
        hs_code_e        hs;
        logic            tx_pid;
        logic            irq;
        logic [ST_W-1:0] set_m;
        logic            tgl_wr;
        logic            tgl_val;
    } hs_result_t;

    function automatic hs_result_t hs_decide(
        input tok_kind_e       kind,
        input logic [ST_W-1:0] st,
        input logic            stall,
        input logic            is_ctrl,
        input logic            irq_dis,
        input logic            last,
        input logic            rx_pid
    );
        hs_result_t r;
        logic       ok;
        r  = '0;
        ok = 1'b0;
        case (kind)
            TK_SETUP: begin
                r.hs           = HS_ACK;
                r.set_m[B_SETP] = 1'b1;
                r.set_m[B_HOLD] = 1'b1;
                r.tgl_wr       = 1'b1;
                r.tgl_val      = 1'b1;
            end
            TK_IN, TK_OUT: begin
                if (stall) begin
                    r.hs           = HS_STALL;
                    r.set_m[B_STL] = 1'b1;
                end else if ((is_ctrl && st[B_SETP]) || st[B_HOLD]) begin
                    r.hs           = HS_NAK;
                    r.set_m[B_UOF] = 1'b1;
                end else begin
                    r.hs = HS_ACK;
                    if (kind == TK_IN) begin
                        r.tx_pid = st[B_TGL];
                        ok       = 1'b1;
                    end else begin
                        ok = (rx_pid == st[B_TGL]);
                    end
                    if (ok) begin
                        r.tgl_wr        = 1'b1;
                        r.tgl_val       = ~st[B_TGL];
                        r.set_m[B_HOLD] = 1'b1;
                        if (last) begin
                            r.set_m[B_TC] = 1'b1;
                            r.irq         = ~irq_dis;
                        end
                    end
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import ep_hs_pkg::*;
(
    input  logic            tok_valid,
    input  tok_kind_e       tok_kind,
    input  logic [ST_W-1:0] tok_st,
    input  logic            stall,
    input  logic            is_ctrl,
    input  logic            irq_dis,
    input  logic            last,
    input  logic            rx_pid,
    output hs_result_t      res
);
    always_comb begin
        if (tok_valid) begin
            res = hs_decide(tok_kind, tok_st, stall, is_ctrl, irq_dis, last, rx_pid);
        end else begin
            res = '0;
        end
    end
endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg
    import ep_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we,
    input  logic [ST_W-1:0] sw_set,
    input  logic [ST_W-1:0] sw_clr,
    input  logic [ST_W-1:0] sw_tgl,
    input  logic            hw_we,
    input  logic [ST_W-1:0] hw_set,
    input  logic            hw_tgl_wr,
    input  logic            hw_tgl_val,
    output logic [ST_W-1:0] st
);
    logic [ST_W-1:0] sw_v;
    logic [ST_W-1:0] nxt;

    always_comb begin
        sw_v = sw_we ? (((st | sw_set) & ~sw_clr) ^ sw_tgl) : st;
        nxt  = sw_v;
        if (hw_we) begin
            nxt = nxt | hw_set;
            if (hw_tgl_wr) begin
                nxt[B_TGL] = hw_tgl_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nxt & ST_USED;
        end
    end
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
    import ep_hs_pkg::*;
#(
    parameter int NUM_EP = 8,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_valid,
    input  logic [EPW-1:0]    tok_ep,
    input  logic [1:0]        tok_kind,
    input  logic              tok_last,
    input  logic              rx_pid,
    input  logic [NUM_EP-1:0] ep_ctrl_type,
    input  logic [NUM_EP-1:0] ep_stall_en,
    input  logic [NUM_EP-1:0] ep_tc_irq_dis,
    input  logic              sw_we,
    input  logic [EPW-1:0]    sw_ep,
    input  logic [7:0]        sw_set,
    input  logic [7:0]        sw_clr,
    input  logic [7:0]        sw_tgl,
    input  logic [EPW-1:0]    rd_ep,
    output logic [7:0]        rd_status,
    input  logic              irq_clr,
    output logic [1:0]        hs_code,
    output logic              tx_pid,
    output logic              tc_irq
);
    logic [ST_W-1:0] st_arr [NUM_EP];
    logic [ST_W-1:0] tok_st;
    hs_result_t      res;

    assign tok_st    = st_arr[tok_ep];
    assign rd_status = st_arr[rd_ep];

    ep_hs_decide u_dec (
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind_e'(tok_kind)),
        .tok_st    (tok_st),
        .stall     (ep_stall_en[tok_ep]),
        .is_ctrl   (ep_ctrl_type[tok_ep]),
        .irq_dis   (ep_tc_irq_dis[tok_ep]),
        .last      (tok_last),
        .rx_pid    (rx_pid),
        .res       (res)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        ep_status_reg u_st (
            .clk        (clk),
            .rst        (rst),
            .sw_we      (sw_we && (sw_ep == EPW'(g))),
            .sw_set     (sw_set),
            .sw_clr     (sw_clr),
            .sw_tgl     (sw_tgl),
            .hw_we      (tok_valid && (tok_ep == EPW'(g))),
            .hw_set     (res.set_m),
            .hw_tgl_wr  (res.tgl_wr),
            .hw_tgl_val (res.tgl_val),
            .st         (st_arr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_code <= HS_NONE;
            tx_pid  <= 1'b0;
            tc_irq  <= 1'b0;
        end else begin
            hs_code <= res.hs;
            tx_pid  <= res.tx_pid;
            tc_irq  <= res.irq | (tc_irq & ~irq_clr);
        end
    end
endmodule

// File: rtl/ep_hs_chk.sv
module ep_hs_chk #(
    parameter int NUM_EP = 8,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              tok_valid,
    input logic [EPW-1:0]    tok_ep,
    input logic [1:0]        tok_kind,
    input logic              tok_last,
    input logic [NUM_EP-1:0] ep_stall_en,
    input logic              irq_clr,
    input logic [1:0]        hs_code,
    input logic              tc_irq,
    input logic [7:0]        rd_status
);
    // R13
    idle_none_chk: assert property (@(posedge clk) disable iff (rst)
        !tok_valid |=> hs_code == 2'b00);

    // R2
    setup_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == 2'b10) |=> hs_code == 2'b01);

    // R3
    stall_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind[1] == 1'b0 && ep_stall_en[tok_ep]) |=> hs_code == 2'b11);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_irq) |-> $past(tok_valid && tok_last && tok_kind[1] == 1'b0));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_irq && !irq_clr) |=> tc_irq);

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_status[7] == 1'b0 && rd_status[2] == 1'b0));
endmodule

bind ep_hs_ctrl ep_hs_chk #(.NUM_EP(NUM_EP)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .tok_valid   (tok_valid),
    .tok_ep      (tok_ep),
    .tok_kind    (tok_kind),
    .tok_last    (tok_last),
    .ep_stall_en (ep_stall_en),
    .irq_clr     (irq_clr),
    .hs_code     (hs_code),
    .tc_irq      (tc_irq),
    .rd_status   (rd_status)
);

// File: tb/test_ep_hs_ctrl.sv
module test_ep_hs_ctrl;
    localparam int NEP = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tok_valid = 1'b0;
    logic [2:0]     tok_ep = '0;
    logic [1:0]     tok_kind = '0;
    logic           tok_last = 1'b0;
    logic           rx_pid = 1'b0;
    logic [NEP-1:0] ep_ctrl_type = '0;
    logic [NEP-1:0] ep_stall_en = '0;
    logic [NEP-1:0] ep_tc_irq_dis = '0;
    logic           sw_we = 1'b0;
    logic [2:0]     sw_ep = '0;
    logic [7:0]     sw_set = '0;
    logic [7:0]     sw_clr = '0;
    logic [7:0]     sw_tgl = '0;
    logic [2:0]     rd_ep = '0;
    logic [7:0]     rd_status;
    logic           irq_clr = 1'b0;
    logic [1:0]     hs_code;
    logic           tx_pid;
    logic           tc_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_st [NEP];
    logic       m_irq = 1'b0;

    always #5 clk = ~clk;

    ep_hs_ctrl #(.NUM_EP(NEP)) i_ep_hs_ctrl (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .tok_kind(tok_kind), .tok_last(tok_last), .rx_pid(rx_pid),
        .ep_ctrl_type(ep_ctrl_type), .ep_stall_en(ep_stall_en),
        .ep_tc_irq_dis(ep_tc_irq_dis), .sw_we(sw_we), .sw_ep(sw_ep),
        .sw_set(sw_set), .sw_clr(sw_clr), .sw_tgl(sw_tgl), .rd_ep(rd_ep),
        .rd_status(rd_status), .irq_clr(irq_clr), .hs_code(hs_code),
        .tx_pid(tx_pid), .tc_irq(tc_irq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: optional event, optional firmware write, optional irq clear.
    task automatic step(input logic tv, input logic [2:0] ep, input logic [1:0] kd,
                        input logic lst, input logic pid,
                        input logic sv, input logic [2:0] sep,
                        input logic [7:0] st_s, input logic [7:0] st_c, input logic [7:0] st_t,
                        input logic ic, input string tag_in);
        logic [7:0] cur;
        logic [7:0] hset;
        logic       hw_t, hw_tv, e_pid, e_irq;
        logic [1:0] e_hs;
        string      tg;
        cur = m_st[ep];
        hset = '0; hw_t = 0; hw_tv = 0; e_pid = 0; e_irq = 0; e_hs = 2'd0; tg = "R13";
        if (tv && kd == 2'd2) begin
            e_hs = 2'd1; hset = 8'h12; hw_t = 1; hw_tv = 1; tg = "R2";
        end else if (tv && kd != 2'd3) begin
            if (ep_stall_en[ep]) begin
                e_hs = 2'd3; hset = 8'h08; tg = "R3";
            end else if (ep_ctrl_type[ep] && cur[4]) begin
                e_hs = 2'd2; hset = 8'h40; tg = "R4";
            end else if (cur[1]) begin
                e_hs = 2'd2; hset = 8'h40; tg = "R5";
            end else begin
                e_hs = 2'd1;
                if (kd == 2'd1 || pid == cur[0]) begin
                    tg = (kd == 2'd1) ? "R6" : "R7";
                    if (kd == 2'd1) e_pid = cur[0];
                    hw_t = 1; hw_tv = ~cur[0]; hset = 8'h02;
                    if (lst) begin
                        hset[5] = 1'b1;
                        e_irq = ~ep_tc_irq_dis[ep];
                        tg = "R9";
                    end
                end else begin
                    tg = "R8";
                end
            end
        end
        if (tag_in != "") tg = tag_in;
        if (sv) m_st[sep] = (((m_st[sep] | st_s) & ~st_c) ^ st_t) & 8'h7B;
        if (tv) begin
            m_st[ep] = m_st[ep] | hset;
            if (hw_t) m_st[ep][0] = hw_tv;
            m_st[ep] = m_st[ep] & 8'h7B;
        end
        m_irq = e_irq | (m_irq & ~ic);

        tok_valid = tv; tok_ep = ep; tok_kind = kd; tok_last = lst; rx_pid = pid;
        sw_we = sv; sw_ep = sep; sw_set = st_s; sw_clr = st_c; sw_tgl = st_t; irq_clr = ic;
        @(posedge clk);
        @(negedge clk);
        tok_valid = 0; sw_we = 0; irq_clr = 0;
        check(tg, "hs_code", int'(hs_code), int'(e_hs));
        check(tg, "tx_pid", int'(tx_pid), int'(e_pid));
        rd_ep = ep; #1;
        check(tg, "status(event ep)", int'(rd_status), int'(m_st[ep]));
        rd_ep = sep; #1;
        check(tg, "status(write ep)", int'(rd_status), int'(m_st[sep]));
        check(tg, "tc_irq", int'(tc_irq), int'(m_irq));
    endtask

    task automatic idle(input string tg);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tg);
    endtask

    task automatic wr(input logic [2:0] e, input logic [7:0] s, input logic [7:0] c,
                      input logic [7:0] t, input string tg);
        step(0, e, 0, 0, 0, 1, e, s, c, t, 0, tg);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int i = 0; i < NEP; i++) m_st[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int i = 0; i < NEP; i++) begin
            rd_ep = 3'(i); #1;
            check("R1", "reset status", int'(rd_status), 0);
        end
        check("R1", "reset hs_code", int'(hs_code), 0);
        check("R1", "reset tc_irq", int'(tc_irq), 0);

        ep_ctrl_type = 8'h01;
        idle("R13");
        step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R2");       // SETUP on ep0
        wr(0, 0, 8'h02, 0, "R11");                          // drop hold
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");       // IN with setup pending
        wr(0, 0, 8'h50, 0, "R11");
        step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R6");       // IN ACK, last
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");       // OUT while hold
        ep_stall_en = 8'h01;
        step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R2");       // SETUP still ACK under stall
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        ep_stall_en = 8'h00;
        step(1, 3, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8");       // mismatched PID
        step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");       // matching PID
        wr(3, 0, 8'h02, 0, "R11");
        step(1, 3, 0, 0, 1, 1, 3, 0, 8'h03, 0, 0, "R12");  // hw set vs sw clear
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");      // clear irq
        wr(3, 0, 8'h02, 0, "R11");
        ep_tc_irq_dis = 8'h08;
        step(1, 3, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R9");       // last, irq suppressed
        ep_tc_irq_dis = 8'h00;
        wr(3, 0, 8'h02, 0, "R11");
        step(1, 3, 0, 1, 1, 0, 0, 0, 0, 0, 1, "R10");      // set wins over clear
        wr(5, 8'hFF, 0, 0, "R11");
        wr(5, 0, 0, 8'h01, "R11");
        wr(5, 0, 8'h7F, 8'h04, "R11");
        idle("R13");

        for (int n = 0; n < 600; n++) begin
            logic       tv, sv;
            logic [7:0] cm;
            if (n % 60 == 0) begin
                ep_ctrl_type  = 8'($urandom);
                ep_stall_en   = 8'($urandom & $urandom & $urandom);
                ep_tc_irq_dis = 8'($urandom);
            end
            tv = ($urandom % 5) != 0;
            sv = ($urandom % 3) == 0;
            cm = 8'($urandom) | 8'h12;
            step(tv, 3'($urandom), 2'($urandom % 3), 1'($urandom), 1'($urandom),
                 sv, 3'($urandom), 8'($urandom & $urandom & $urandom), cm,
                 8'($urandom & $urandom & $urandom), 1'(($urandom % 7) == 0), "");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule